// File: doc/BRIEF.md
# Atomic Bit Test-and-Set Engine

This block claims a semaphore held in one 16-bit word with a single indivisible read-modify-write. A command carries a target address and a bit mask. The block reads the word over a simple request/acknowledge memory bus and tests the bits the mask selects. It then sets those bits and writes the word back to the same address. A lock output stays high from the read request through the end of the write. The memory side uses it to keep any other agent out of the word between the two accesses.

When the write completes, the bus reports whether it took effect. The block then raises a one-cycle `done` and presents a test flag. A flag of 0 means the semaphore was free and is now owned exclusively. A flag of 1 means the claim failed, either because a selected bit was already set or because the write-back was refused. A later conditional branch uses this flag to retry. A register-destination command skips the bus entirely and works on a word supplied with the command. In that case the write is always treated as successful.

Commands enter on a valid/ready handshake. `cmd_ready` is high only while the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While the engine is busy, the source must hold its command and wait. The bus, status and result pins are plain levels.

Top module: `bit_claim_engine`

## Requirements
- R1: `cmd_ready` is high exactly when the engine is idle. A command is taken on an edge with `cmd_valid` and `cmd_ready` both high. `busy` is high from the cycle after acceptance through the `done` cycle.
- R2: For a memory command, `mem_rd_req` rises in the cycle after acceptance, with `mem_addr` equal to the command address. It stays high until the edge where `mem_rd_ack` is sampled high. `mem_rd_ack` counts only from the second request cycle on, and `mem_rdata` is captured on that edge.
- R3: After the read, `mem_wr_req` is raised with the same address and `mem_wdata` equal to the read word OR the mask. It stays high until the edge where `mem_wr_ack` is high. The write is made even when the selected bits were already set.
- R4: `mem_lock` is high in every cycle in which `mem_rd_req` or `mem_wr_req` is high, and in the cycles between them. It is low in idle, in the `done` cycle and during register commands.
- R5: If any mask-selected bit of the read word is 1, the test flag is 1, whatever the write status.
- R6: If all selected bits were 0 and `mem_wr_ok` is 0 on the write-acknowledge edge (0 = write failed, 1 = succeeded), the test flag is 1.
- R7: The test flag is 0 only when all selected bits were 0 and the write succeeded.
- R8: A register command (`cmd_to_reg` = 1) makes no bus request and raises no lock. `done` comes in the cycle after acceptance, with `result_word` = `cmd_reg_value` OR mask and the flag = (any selected bit of `cmd_reg_value` was 1).
- R9: `done` is high for exactly one cycle per command. `test_flag` keeps its value until the next `done`. `result_word` shows the word written back (memory or register) while `done` is high.
- R10: A synchronous active-high reset returns the engine to idle, with lock and requests low, `test_flag` 0 and `cmd_ready` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_addr | input | ADDR_W | Word address of the semaphore |
| cmd_mask | input | DATA_W | Bits to test and set |
| cmd_to_reg | input | 1 | 1 = register destination, no bus access |
| cmd_reg_value | input | DATA_W | Register word for a register command |
| busy | output | 1 | Command in progress |
| mem_rd_req | output | 1 | Read request |
| mem_wr_req | output | 1 | Write request |
| mem_lock | output | 1 | Read and write form one indivisible sequence |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | DATA_W | Write-back word |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read word |
| mem_wr_ack | input | 1 | Write completed |
| mem_wr_ok | input | 1 | Write status, 1 = succeeded |
| done | output | 1 | One-cycle completion pulse |
| test_flag | output | 1 | 1 = claim failed, 0 = semaphore acquired |
| result_word | output | DATA_W | Word written back, valid with done |

## Verification
The bench covers the four combinations of old bit value and write status. An engine that ignored the write status would report a refused write as a successful claim. An engine that skipped the write when the bit was already set would leave the bus waiting on the locked sequence. The bench holds acknowledges back for several cycles and pulses `mem_rd_ack` during the first request cycle. An engine that sampled too early, or dropped a request before its acknowledge, would capture the wrong word or show a gap in the lock. Register commands, a multi-bit mask and a reset in mid-sequence close the set. A wrong register path would touch the bus, and a wrong reset would leave the lock stuck high.

// File: rtl/bce_pkg.sv
package bce_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_RD_ADDR = 3'd1,
    S_RD_DATA = 3'd2,
    S_WR_ADDR = 3'd3,
    S_WR_DATA = 3'd4,
    S_DONE    = 3'd5
  } bce_state_e;
endpackage

// File: rtl/bce_bitop.sv
module bce_bitop #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [DATA_W-1:0] mask_in,
  output logic              any_set,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    any_set = |(word_in & mask_in);
    merged  = word_in | mask_in;
  end
endmodule

// File: rtl/bce_sequencer.sv
module bce_sequencer
  import bce_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_mem,
  input  logic       start_reg,
  input  logic       rd_ack,
  input  logic       wr_ack,
  output bce_state_e state
);
  bce_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (start_reg)      nxt = S_DONE;
        else if (start_mem) nxt = S_RD_ADDR;
      end
      S_RD_ADDR: nxt = S_RD_DATA;
      S_RD_DATA: if (rd_ack) nxt = S_WR_ADDR;
      S_WR_ADDR: nxt = S_WR_DATA;
      S_WR_DATA: if (wr_ack) nxt = S_DONE;
      S_DONE:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/bce_verdict.sv
module bce_verdict (
  input  logic clk,
  input  logic rst,
  input  logic reg_load,
  input  logic reg_hit,
  input  logic wr_load,
  input  logic mem_hit,
  input  logic wr_ok,
  output logic t_flag
);
  always_ff @(posedge clk) begin
    if (rst)           t_flag <= 1'b0;
    else if (reg_load) t_flag <= reg_hit;
    else if (wr_load)  t_flag <= mem_hit | ~wr_ok;
  end
endmodule

// File: rtl/bit_claim_engine.sv
module bit_claim_engine
  import bce_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_mask,
  input  logic              cmd_to_reg,
  input  logic [DATA_W-1:0] cmd_reg_value,
  output logic              busy,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rd_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_wr_ack,
  input  logic              mem_wr_ok,
  output logic              done,
  output logic              test_flag,
  output logic [DATA_W-1:0] result_word
);
  bce_state_e        state;
  logic              accept, start_mem, start_reg, rd_take, wr_take;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q, merged_q, op_word, op_mask, op_merged;
  logic              hit_q, op_hit;

  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid & cmd_ready;
  assign start_mem = accept & ~cmd_to_reg;
  assign start_reg = accept & cmd_to_reg;
  assign rd_take   = (state == S_RD_DATA) & mem_rd_ack;
  assign wr_take   = (state == S_WR_DATA) & mem_wr_ack;

  // In idle the operand is the register word; afterwards it is the bus word.
  assign op_word = cmd_ready ? cmd_reg_value : mem_rdata;
  assign op_mask = cmd_ready ? cmd_mask : mask_q;

  bce_bitop #(.DATA_W(DATA_W)) u_bitop (
    .word_in (op_word),
    .mask_in (op_mask),
    .any_set (op_hit),
    .merged  (op_merged)
  );

  bce_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_mem (start_mem),
    .start_reg (start_reg),
    .rd_ack    (mem_rd_ack),
    .wr_ack    (mem_wr_ack),
    .state     (state)
  );

  bce_verdict u_verdict (
    .clk      (clk),
    .rst      (rst),
    .reg_load (start_reg),
    .reg_hit  (op_hit),
    .wr_load  (wr_take),
    .mem_hit  (hit_q),
    .wr_ok    (mem_wr_ok),
    .t_flag   (test_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      mask_q   <= '0;
      merged_q <= '0;
      hit_q    <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= cmd_addr;
        mask_q <= cmd_mask;
      end
      if (start_reg || rd_take) begin
        merged_q <= op_merged;
        hit_q    <= op_hit;
      end
    end
  end

  always_comb begin
    mem_rd_req  = (state == S_RD_ADDR) || (state == S_RD_DATA);
    mem_wr_req  = (state == S_WR_ADDR) || (state == S_WR_DATA);
    mem_lock    = mem_rd_req || mem_wr_req;
    mem_addr    = addr_q;
    mem_wdata   = merged_q;
    busy        = !cmd_ready;
    done        = (state == S_DONE);
    result_word = merged_q;
  end
endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic              busy,
  input logic              mem_rd_req,
  input logic              mem_wr_req,
  input logic              mem_lock,
  input logic              mem_rd_ack,
  input logic              mem_wr_ack,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mask_q,
  input logic              done,
  input logic              test_flag
);
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !busy);

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_ack && !$rose(mem_rd_req)) |=> mem_rd_req);

  p_wdata_mask_r3: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> ((mem_wdata & mask_q) == mask_q));

  p_wr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !mem_wr_ack && !$rose(mem_wr_req)) |=> mem_wr_req);

  p_lock_cover_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req || mem_wr_req) |-> mem_lock);

  p_one_req_r4: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && mem_wr_req));

  p_no_lock_done_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_lock);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(test_flag) || done);
endmodule

bind bit_claim_engine bce_checker #(.DATA_W(DATA_W)) u_bce_checker (
  .clk        (clk),
  .rst        (rst),
  .cmd_ready  (cmd_ready),
  .busy       (busy),
  .mem_rd_req (mem_rd_req),
  .mem_wr_req (mem_wr_req),
  .mem_lock   (mem_lock),
  .mem_rd_ack (mem_rd_ack),
  .mem_wr_ack (mem_wr_ack),
  .mem_wdata  (mem_wdata),
  .mask_q     (mask_q),
  .done       (done),
  .test_flag  (test_flag)
);

// File: tb/test_bit_claim_engine.sv
module test_bit_claim_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0, cmd_ready, cmd_to_reg = 1'b0, busy;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_mask = '0, cmd_reg_value = '0;
  logic          mem_rd_req, mem_wr_req, mem_lock;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, result_word;
  logic          mem_rd_ack = 1'b0, mem_wr_ack = 1'b0, mem_wr_ok = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          done, test_flag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_claim_engine #(.DATA_W(DW), .ADDR_W(AW)) i_bit_claim_engine (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_mask(cmd_mask), .cmd_to_reg(cmd_to_reg), .cmd_reg_value(cmd_reg_value),
    .busy(busy), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd_ack(mem_rd_ack), .mem_rdata(mem_rdata), .mem_wr_ack(mem_wr_ack),
    .mem_wr_ok(mem_wr_ok), .done(done), .test_flag(test_flag),
    .result_word(result_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Memory command with a bench-side bus responder.
  task automatic mem_claim(input logic [AW-1:0] addr, input logic [DW-1:0] mask,
                           input logic [DW-1:0] word, input logic ok,
                           input int rd_wait, input int wr_wait, input logic early_ack);
    logic exp_t;
    exp_t = (|(word & mask)) | ~ok;
    @(negedge clk);
    check("R1 ready in idle", cmd_ready, 1);
    cmd_valid = 1; cmd_to_reg = 0; cmd_addr = addr; cmd_mask = mask;
    @(negedge clk);                       // first read request cycle
    cmd_valid = 0;
    check("R1 busy after accept", busy, 1);
    check("R1 not ready while busy", cmd_ready, 0);
    check("R2 read request", mem_rd_req, 1);
    check("R2 read address", mem_addr, addr);
    check("R4 lock on read", mem_lock, 1);
    if (early_ack) begin
      mem_rd_ack = 1; mem_rdata = ~word; // must be ignored (R2)
    end
    @(negedge clk);
    mem_rd_ack = 0;
    for (int i = 0; i < rd_wait; i++) begin
      check("R2 read held", mem_rd_req, 1);
      check("R4 lock held", mem_lock, 1);
      @(negedge clk);
    end
    mem_rd_ack = 1; mem_rdata = word;
    @(negedge clk);                       // first write request cycle
    mem_rd_ack = 0; mem_rdata = '0;
    check("R3 write request", mem_wr_req, 1);
    check("R4 no read during write", mem_rd_req, 0);
    check("R3 write address", mem_addr, addr);
    check("R3 write data", mem_wdata, word | mask);
    check("R4 lock on write", mem_lock, 1);
    @(negedge clk);
    for (int i = 0; i < wr_wait; i++) begin
      check("R3 write held", mem_wr_req, 1);
      @(negedge clk);
    end
    mem_wr_ack = 1; mem_wr_ok = ok;
    @(negedge clk);                       // done cycle
    mem_wr_ack = 0; mem_wr_ok = 0;
    check("R9 done", done, 1);
    check("R5 R6 R7 test flag", test_flag, exp_t);
    check("R9 result word", result_word, word | mask);
    check("R4 lock low at done", mem_lock, 0);
    check("R1 busy at done", busy, 1);
    @(negedge clk);
    check("R9 done single cycle", done, 0);
    check("R9 flag held", test_flag, exp_t);
    check("R1 idle again", cmd_ready, 1);
  endtask

  task automatic reg_claim(input logic [DW-1:0] value, input logic [DW-1:0] mask);
    @(negedge clk);
    cmd_valid = 1; cmd_to_reg = 1; cmd_reg_value = value; cmd_mask = mask;
    @(negedge clk);
    cmd_valid = 0; cmd_to_reg = 0;
    check("R8 done next cycle", done, 1);
    check("R8 flag", test_flag, |(value & mask));
    check("R8 result", result_word, value | mask);
    check("R8 no read", mem_rd_req, 0);
    check("R8 no write", mem_wr_req, 0);
    check("R8 no lock", mem_lock, 0);
    @(negedge clk);
    check("R8 idle after", cmd_ready, 1);
    check("R8 still no bus", mem_rd_req | mem_wr_req | mem_lock, 0);
  endtask

  task automatic reset_state();
    check("R10 ready", cmd_ready, 1);
    check("R10 lock", mem_lock, 0);
    check("R10 requests", mem_rd_req | mem_wr_req, 0);
    check("R10 flag", test_flag, 0);
    check("R10 done", done, 0);
  endtask

  task automatic reset_midway();
    @(negedge clk);
    cmd_valid = 1; cmd_to_reg = 0; cmd_addr = 16'h0040; cmd_mask = 16'h0001;
    @(negedge clk);
    cmd_valid = 0;
    @(negedge clk);
    check("R10 locked before reset", mem_lock, 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    reset_state();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    reset_state();
    mem_claim(16'h0100, 16'h0004, 16'h0000, 1, 0, 0, 0);  // free, ok -> T=0 (R7)
    mem_claim(16'h0101, 16'h0004, 16'h0004, 1, 2, 1, 0);  // occupied -> T=1 (R5)
    mem_claim(16'h0102, 16'h8000, 16'h7fff, 0, 1, 3, 1);  // free, refused -> T=1 (R6)
    mem_claim(16'h0103, 16'h0010, 16'h0010, 0, 0, 2, 0);  // occupied, refused (R5)
    mem_claim(16'h0104, 16'h0300, 16'h0100, 1, 3, 0, 1);  // multi-bit, one set (R5)
    mem_claim(16'hfffe, 16'h0001, 16'ha5a4, 1, 1, 1, 1);  // free, ok, late acks (R7)
    reg_claim(16'h0000, 16'h0020);                        // reg free (R8)
    reg_claim(16'h0020, 16'h0020);                        // reg occupied (R8)
    reset_midway();
    mem_claim(16'h0200, 16'h0002, 16'h0000, 1, 0, 0, 0);  // works after reset
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule